// File: doc/BRIEF.md
# SM Occupancy Limit Calculator

This unit works out how many thread blocks of one kernel can sit on a streaming multiprocessor at the same time. It takes three launch figures: threads per block, registers per thread and shared-memory bytes per block. Threads are grouped in 32-lane warps, and a partial last warp still costs a full warp. For each of three per-SM resources it finds how many blocks fit: the warp slots, the register file and the shared memory. The resident count is the smallest of these three limits and a fixed block cap. From that count it derives the active warps and the occupancy, which is active warps over the SM's warp slots.

The per-SM capacities are parameters. The unit is sequential and has one restoring divider, which runs four divisions in turn: the warp limit, the register limit, the shared-memory limit and then the percentage. A `start` pulse in the idle state captures the inputs. A one-cycle `done` pulse marks the point where every result is valid. The unit also reports a 2-bit code naming the binding resource, and an error flag for a launch that cannot place even one block.

Top module: `sm_occupancy_calc`

## Requirements
- R1: `warps_per_block` equals the thread count divided by 32, rounded up, so a partial warp counts as a whole one (100 threads give 4).
- R2: `lim_warps` equals floor(MAX_WARPS / warps_per_block). It is 0 when the thread count is 0.
- R3: `lim_regs` equals floor(REG_FILE / (regs_per_thread × 32 × warps_per_block)). When that product is zero, `lim_regs` reports MAX_BLOCKS.
- R4: `lim_smem` equals floor(SMEM_BYTES / smem_per_block). A zero byte count reports MAX_BLOCKS.
- R5: `resident_blocks` is the minimum of the three limits and MAX_BLOCKS.
- R6: `active_warps` equals resident_blocks × warps_per_block. `occupancy_pct` equals floor(active_warps × 100 / MAX_WARPS) as an 8-bit value.
- R7: `bottleneck` encodes the binding limit: 0 for warps, 1 for registers, 2 for shared memory, 3 for the block cap. On a tie the lower code wins, and code 3 appears only when the cap is strictly below all three limits.
- R8: `error` is 1 exactly when resident_blocks is 0. In that case active_warps and occupancy_pct are also 0.
- R9: `start` is taken only when the unit is idle. A `start` during a computation has no effect on the results it delivers.
- R10: After reset, `done` is 0 and the result outputs are 0. `done` is high for exactly one cycle per accepted start, and the results hold their values from `done` until the next accepted start, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation (taken when idle) |
| threads_per_block | input | THR_W | Threads in one block |
| regs_per_thread | input | REG_W | Registers used by each thread |
| smem_per_block | input | SMEM_W | Shared-memory bytes used by one block |
| done | output | 1 | One-cycle pulse when results are valid |
| warps_per_block | output | THR_W-4 | Warps per block, rounded up |
| lim_warps | output | DIV_W | Blocks allowed by warp slots |
| lim_regs | output | DIV_W | Blocks allowed by the register file |
| lim_smem | output | DIV_W | Blocks allowed by shared memory |
| resident_blocks | output | clog2(MAX_BLOCKS+1) | Final resident block count |
| active_warps | output | clog2(MAX_WARPS+1) | Warps resident on the SM |
| occupancy_pct | output | 8 | Occupancy in percent, rounded down |
| bottleneck | output | 2 | Code of the binding resource |
| error | output | 1 | No block fits |

## Verification
The bench builds the unit with its default capacities: 64 warp slots, a cap of 32 blocks, a 65536-entry register file and 229376 bytes of shared memory. With these values each of the four bottleneck codes can be produced by small launch figures. The same values allow both a two-way tie and an exact fit of shared memory (one block that uses all of it). They also allow overflow of registers and of shared memory, a zero-thread launch and a 2047-thread block that fills every warp slot. The 32-bit divider width leaves room for the largest register product these widths allow.

// File: rtl/sm_occupancy_calc.sv
module sm_occupancy_calc #(
  parameter int MAX_WARPS  = 64,
  parameter int MAX_BLOCKS = 32,
  parameter int REG_FILE   = 65536,
  parameter int SMEM_BYTES = 229376,
  parameter int THR_W      = 11,
  parameter int REG_W      = 9,
  parameter int SMEM_W     = 18,
  parameter int DIV_W      = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [THR_W-1:0]                  threads_per_block,
  input  logic [REG_W-1:0]                  regs_per_thread,
  input  logic [SMEM_W-1:0]                 smem_per_block,
  output logic                              done,
  output logic [THR_W-5:0]                  warps_per_block,
  output logic [DIV_W-1:0]                  lim_warps,
  output logic [DIV_W-1:0]                  lim_regs,
  output logic [DIV_W-1:0]                  lim_smem,
  output logic [$clog2(MAX_BLOCKS+1)-1:0]   resident_blocks,
  output logic [$clog2(MAX_WARPS+1)-1:0]    active_warps,
  output logic [7:0]                        occupancy_pct,
  output logic [1:0]                        bottleneck,
  output logic                              error
);
  localparam int LANE_LOG2 = 5;
  localparam int WPB_W     = THR_W - LANE_LOG2 + 1;
  localparam int BLK_W     = $clog2(MAX_BLOCKS + 1);
  localparam int AW_W      = $clog2(MAX_WARPS + 1);
  localparam int CNT_W     = $clog2(DIV_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN} state_t;

  state_t             st;
  logic [THR_W-1:0]   thr_q;
  logic [REG_W-1:0]   reg_q;
  logic [SMEM_W-1:0]  smem_q;
  logic [1:0]         stage;
  logic [CNT_W-1:0]   cnt;
  logic [DIV_W-1:0]   rem, quo;
  logic [DIV_W-1:0]   lw_q, lr_q, ls_q;
  logic [7:0]         pct_q;
  logic [BLK_W-1:0]   blk_q;
  logic [AW_W-1:0]    aw_q;
  logic [1:0]         bn_q;
  logic               err_q, done_q;

  logic [THR_W:0]     thr_rnd;
  logic [WPB_W-1:0]   wpb;
  logic [DIV_W-1:0]   reg_div, blk_c, aw_c;
  logic [1:0]         bn_c;
  logic [DIV_W-1:0]   dvd, dvs, spec;
  logic [DIV_W-1:0]   rem_sh, rem_nx, quo_nx;
  logic               wr_en;
  logic [DIV_W-1:0]   wr_val;

  assign thr_rnd = {1'b0, thr_q} + (THR_W+1)'((1 << LANE_LOG2) - 1);
  assign wpb     = WPB_W'(thr_rnd >> LANE_LOG2);
  assign reg_div = (DIV_W'(reg_q) * DIV_W'(wpb)) << LANE_LOG2;

  always_comb begin
    blk_c = DIV_W'(MAX_BLOCKS);
    bn_c  = 2'd3;
    if (ls_q <= blk_c) begin blk_c = ls_q; bn_c = 2'd2; end
    if (lr_q <= blk_c) begin blk_c = lr_q; bn_c = 2'd1; end
    if (lw_q <= blk_c) begin blk_c = lw_q; bn_c = 2'd0; end
  end
  assign aw_c = blk_c * DIV_W'(wpb);

  always_comb begin
    case (stage)
      2'd0:    begin dvd = DIV_W'(MAX_WARPS);  dvs = DIV_W'(wpb);    spec = '0; end
      2'd1:    begin dvd = DIV_W'(REG_FILE);   dvs = reg_div;        spec = DIV_W'(MAX_BLOCKS); end
      2'd2:    begin dvd = DIV_W'(SMEM_BYTES); dvs = DIV_W'(smem_q); spec = DIV_W'(MAX_BLOCKS); end
      default: begin dvd = aw_c * DIV_W'(100); dvs = DIV_W'(MAX_WARPS); spec = '0; end
    endcase
  end

  assign rem_sh = {rem[DIV_W-2:0], quo[DIV_W-1]};
  assign rem_nx = (rem_sh >= dvs) ? rem_sh - dvs : rem_sh;
  assign quo_nx = {quo[DIV_W-2:0], rem_sh >= dvs};
  assign wr_en  = (st == S_LOAD && dvs == '0) || (st == S_RUN && cnt == CNT_W'(1));
  assign wr_val = (st == S_LOAD) ? spec : quo_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; thr_q <= '0; reg_q <= '0; smem_q <= '0;
      stage <= '0; cnt <= '0; rem <= '0; quo <= '0;
      lw_q <= '0; lr_q <= '0; ls_q <= '0; pct_q <= '0;
      blk_q <= '0; aw_q <= '0; bn_q <= '0; err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          thr_q <= threads_per_block; reg_q <= regs_per_thread; smem_q <= smem_per_block;
          stage <= '0; st <= S_LOAD;
        end
        S_LOAD: begin
          rem <= '0; quo <= dvd; cnt <= CNT_W'(DIV_W); st <= S_RUN;
        end
        default: begin
          rem <= rem_nx; quo <= quo_nx; cnt <= cnt - CNT_W'(1);
        end
      endcase
      if (wr_en) begin
        case (stage)
          2'd0:    lw_q  <= wr_val;
          2'd1:    lr_q  <= wr_val;
          2'd2:    ls_q  <= wr_val;
          default: pct_q <= wr_val[7:0];
        endcase
        if (stage == 2'd3) begin
          blk_q  <= BLK_W'(blk_c);
          aw_q   <= AW_W'(aw_c);
          bn_q   <= bn_c;
          err_q  <= (blk_c == '0);
          done_q <= 1'b1;
          st     <= S_IDLE;
        end else begin
          stage <= stage + 2'd1;
          st    <= S_LOAD;
        end
      end
    end
  end

  assign done            = done_q;
  assign warps_per_block = wpb;
  assign lim_warps       = lw_q;
  assign lim_regs        = lr_q;
  assign lim_smem        = ls_q;
  assign resident_blocks = blk_q;
  assign active_warps    = aw_q;
  assign occupancy_pct   = pct_q;
  assign bottleneck      = bn_q;
  assign error           = err_q;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> ($stable(resident_blocks) && $stable(occupancy_pct) && $stable(bottleneck)));
  assert_min_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (DIV_W'(resident_blocks) <= DIV_W'(MAX_BLOCKS) && DIV_W'(resident_blocks) <= lim_warps
              && DIV_W'(resident_blocks) <= lim_regs && DIV_W'(resident_blocks) <= lim_smem));
  assert_occ_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (occupancy_pct <= 8'd100 && int'(active_warps) <= MAX_WARPS));
  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> (resident_blocks == '0 && active_warps == '0 && occupancy_pct == '0));
  assert_named_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((bottleneck == 2'd0 && lim_warps == DIV_W'(resident_blocks)) ||
              (bottleneck == 2'd1 && lim_regs  == DIV_W'(resident_blocks)) ||
              (bottleneck == 2'd2 && lim_smem  == DIV_W'(resident_blocks)) ||
              (bottleneck == 2'd3 && DIV_W'(resident_blocks) == DIV_W'(MAX_BLOCKS))));
endmodule

// File: tb/test_sm_occupancy_calc.sv
module test_sm_occupancy_calc;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [10:0] thr = '0;
  logic [8:0]  rg = '0;
  logic [17:0] sm = '0;
  logic        done, error;
  logic [6:0]  wpb;
  logic [31:0] lw, lr, ls;
  logic [5:0]  blk;
  logic [6:0]  aw;
  logic [7:0]  pct;
  logic [1:0]  bn;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sm_occupancy_calc i_sm_occupancy_calc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .threads_per_block(thr), .regs_per_thread(rg), .smem_per_block(sm),
    .done(done), .warps_per_block(wpb), .lim_warps(lw), .lim_regs(lr), .lim_smem(ls),
    .resident_blocks(blk), .active_warps(aw), .occupancy_pct(pct),
    .bottleneck(bn), .error(error));

  // thr, regs, smem, wpb, lim_w, lim_r, lim_s, blocks, active, pct, code, err
  localparam int NV = 11;
  localparam int VEC [NV][12] = '{
    '{256,  32, 16384,  8,  8,   8,   14,  8, 64, 100, 0, 0},
    '{128,  64,     0,  4, 16,   8,   32,  8, 32,  50, 1, 0},
    '{64,   16, 32768,  2, 32,  64,    7,  7, 14,  21, 2, 0},
    '{32,    8,  1024,  1, 64, 256,  224, 32, 32,  50, 3, 0},
    '{100,  40,     0,  4, 16,  12,   32, 12, 48,  75, 1, 0},
    '{33,    0,     0,  2, 32,  32,   32, 32, 64, 100, 0, 0},
    '{256,  32, 229377, 8,  8,   8,    0,  0,  0,   0, 2, 1},
    '{1024, 255,    0, 32,  2,   0,   32,  0,  0,   0, 1, 1},
    '{2047,  1,     0, 64,  1,  32,   32,  1, 64, 100, 0, 0},
    '{0,    32,   100,  0,  0,  32, 2293,  0,  0,   0, 0, 1},
    '{96,  255, 229376, 3, 21,   2,    1,  1,  3,   4, 2, 0}
  };

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic launch(int t, int r, int s);
    @(negedge clk);
    thr = 11'(t); rg = 9'(r); sm = 18'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (!ok) check("R10", "done timeout", 0, 1);
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    check("R10", "reset done", done, 0);
    check("R10", "reset blocks", blk, 0);
    check("R10", "reset pct", pct, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      launch(VEC[v][0], VEC[v][1], VEC[v][2]);
      wait_done(ok);
      if (ok) begin
        check("R1", "warps per block", wpb, VEC[v][3]);
        check("R2", "warp limit", lw, VEC[v][4]);
        check("R3", "register limit", lr, VEC[v][5]);
        check("R4", "smem limit", ls, VEC[v][6]);
        check("R5", "resident blocks", blk, VEC[v][7]);
        check("R6", "active warps", aw, VEC[v][8]);
        check("R6", "occupancy pct", pct, VEC[v][9]);
        check("R7", "bottleneck", bn, VEC[v][10]);
        check("R8", "error", error, VEC[v][11]);
        @(negedge clk);
        check("R10", "done one cycle", done, 0);
      end
    end

    // R9: second start during computation is dropped
    launch(128, 64, 0);
    repeat (5) @(negedge clk);
    thr = 11'd32; rg = 9'd8; sm = 18'd1024; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    if (ok) begin
      check("R9", "busy start blocks", blk, 8);
      check("R9", "busy start code", bn, 1);
      check("R9", "busy start wpb", wpb, 4);
      @(negedge clk);
      repeat (300) begin
        check("R9", "no extra done", done, 0);
        @(negedge clk);
      end
    end

    // R10: results hold while inputs move without start
    thr = 11'd64; rg = 9'd200; sm = 18'd5000;
    repeat (20) @(negedge clk);
    check("R10", "hold blocks", blk, 8);
    check("R10", "hold pct", pct, 50);
    check("R10", "hold code", bn, 1);
    check("R10", "hold wpb", wpb, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule